// File: doc/BRIEF.md
# Multi-channel SAR ADC SPI Reader

This block is an SPI master that fetches one conversion from an external successive-approximation converter. A caller presents a request carrying an input number, a single-ended/differential flag and a device-variant code. The block drives chip select low and, for multi-input variants, shifts out a command byte. It then clocks in two result bytes and returns a right-justified result with a one-cycle valid pulse. Single-input variants have no command line, so their frame is receive-only.

The bus runs in SPI mode 0. SCLK idles low and each half period lasts `CLK_DIV_HALF` system clocks. The block drives MOSI while SCLK is low and samples MISO at the rising edge. Bits of the result word are selected by variant. The 13-bit variant is two's complement and is sign-extended to the output width. A differential channel is named by the first input of its pair: channel 1 means the pair in which input 1 is positive and input 0 is negative.

Top module: `sar_spi_reader`

## Requirements
- R1: For variant codes 5 to 8 (4- and 8-input), the command byte sent MSB first is: bit 6 = 1 (start), bit 5 = 1 for single-ended and 0 for differential, and the channel number placed from bit 2 upward. That field is two bits wide for 4-input codes and three bits wide for 8-input codes. All other bits are 0.
- R2: For variant codes 3 and 4 (2-input), the command byte is: bit 4 = 1 (start), bit 3 = single-ended flag, bit 2 = channel bit 0. All other bits are 0.
- R3: For variant codes 0, 1 and 2 (single-input), and for codes 9 to 15, no command is sent. The frame has exactly 16 SCLK rising edges and MOSI stays 0 while chip select is low.
- R4: Multi-input frames have exactly 24 SCLK rising edges with chip select held low throughout. MISO values sampled during the first 8 edges do not affect the result.
- R5: Code 5 and code 7 (10-bit multi-input) return bits [15:6] of the received 16-bit word (first byte in bits 15:8), zero-extended.
- R6: Code 4, code 6 and code 8 (12-bit multi-input) return bits [15:4] of the received word, zero-extended.
- R7: Code 0 (10-bit single-input, and codes 9 to 15) returns received bits [12:3]. Code 1 (12-bit single-input) returns received bits [12:1]. Both are zero-extended.
- R8: Code 2 (13-bit signed) returns received bits [12:0] as two's complement, sign-extended from bit 12 to the output width.
- R9: Code 3 (10-bit 2-input) returns received bits [15:6].
- R10: SCLK is low whenever chip select is high. Successive rising edges within a frame are 2*CLK_DIV_HALF system clocks apart. MOSI changes only while SCLK is low.
- R11: A request is accepted only when busy is low. A request raised while busy is ignored and produces neither a frame nor a result.
- R12: After a frame, chip select stays high for at least 2*CLK_DIV_HALF system clocks before the next frame. res_valid is a single-cycle pulse issued while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_chan | input | 3 | Input number (first input of a differential pair) |
| req_diff | input | 1 | 1 = differential, 0 = single-ended |
| req_variant | input | 4 | Device variant code |
| busy | output | 1 | Frame or inter-frame gap in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | RES_W | Right-justified result |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Command data to converter |
| spi_miso | input | 1 | Result data from converter |

## Verification
A bit counter that is off by one shows at the pins within the same frame. Either the rising-edge count differs from 16 or 24, or the result appears shifted by one bit. A wrong variant decode gives a misplaced command field on MOSI before the first result byte, or a result taken from the wrong bit window on the following valid pulse. A busy flag that drops early or a start qualifier that ignores busy produces an unexpected extra frame and result. The scoreboard reports that extra result as soon as it appears.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    typedef enum logic [3:0] {
        V_1IN_10  = 4'd0,
        V_1IN_12  = 4'd1,
        V_1IN_13S = 4'd2,
        V_2IN_10  = 4'd3,
        V_2IN_12  = 4'd4,
        V_4IN_10  = 4'd5,
        V_4IN_12  = 4'd6,
        V_8IN_10  = 4'd7,
        V_8IN_12  = 4'd8
    } variant_e;

    typedef struct packed {
        logic       has_cmd;
        logic [7:0] cmd;
    } frame_cfg_t;

    localparam int RX_BITS  = 16;
    localparam int CMD_BITS = 8;

    function automatic variant_e norm_variant(input logic [3:0] code);
        return (code > 4'd8) ? V_1IN_10 : variant_e'(code);
    endfunction

    function automatic frame_cfg_t build_cfg(input variant_e v,
                                             input logic [2:0] ch,
                                             input logic diff);
        frame_cfg_t c;
        c.has_cmd = 1'b1;
        unique case (v)
            V_2IN_10, V_2IN_12: c.cmd = {3'b000, 1'b1, ~diff, ch[0], 2'b00};
            V_4IN_10, V_4IN_12: c.cmd = {1'b0, 1'b1, ~diff, 1'b0, ch[1:0], 2'b00};
            V_8IN_10, V_8IN_12: c.cmd = {1'b0, 1'b1, ~diff, ch, 2'b00};
            default: begin
                c.has_cmd = 1'b0;
                c.cmd     = 8'h00;
            end
        endcase
        return c;
    endfunction

    function automatic logic signed [15:0] align_result(input variant_e v,
                                                        input logic [15:0] rx);
        logic signed [15:0] r;
        unique case (v)
            V_1IN_12:                     r = {4'b0, rx[12:1]};
            V_1IN_13S:                    r = {{3{rx[12]}}, rx[12:0]};
            V_2IN_10, V_4IN_10, V_8IN_10: r = {6'b0, rx[15:6]};
            V_2IN_12, V_4IN_12, V_8IN_12: r = {4'b0, rx[15:4]};
            default:                      r = {6'b0, rx[12:3]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl
    import sar_rd_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  frame_cfg_t  cfg,
    input  logic        spi_miso,
    output logic        busy,
    output logic        done,
    output logic [15:0] rx_word,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi
);
    typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} state_e;

    state_e     state;
    logic       tick;
    logic       has_cmd_r;
    logic [7:0] shreg;
    logic [4:0] bitcnt;
    logic [4:0] nbits;
    logic       gapcnt;

    // Half-period timer runs only inside a frame; it restarts at every start.
    sar_sclk_gen #(.HALF(HALF)) u_sclk_gen (
        .clk  (clk),
        .rst  (rst),
        .en   (state != S_IDLE && !start),
        .tick (tick)
    );

    assign busy = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            spi_cs_n  <= 1'b1;
            spi_sclk  <= 1'b0;
            spi_mosi  <= 1'b0;
            shreg     <= '0;
            bitcnt    <= '0;
            nbits     <= '0;
            has_cmd_r <= 1'b0;
            rx_word   <= '0;
            gapcnt    <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    state     <= S_XFER;
                    spi_cs_n  <= 1'b0;
                    has_cmd_r <= cfg.has_cmd;
                    shreg     <= cfg.cmd;
                    spi_mosi  <= cfg.cmd[7];
                    bitcnt    <= '0;
                    nbits     <= cfg.has_cmd ? 5'(CMD_BITS + RX_BITS) : 5'(RX_BITS);
                end
                S_XFER: if (tick) begin
                    if (!spi_sclk) begin
                        spi_sclk <= 1'b1;
                        bitcnt   <= bitcnt + 1'b1;
                        if (!has_cmd_r || bitcnt >= 5'(CMD_BITS))
                            rx_word <= {rx_word[14:0], spi_miso};
                    end else begin
                        spi_sclk <= 1'b0;
                        if (bitcnt == nbits) begin
                            state    <= S_GAP;
                            spi_cs_n <= 1'b1;
                            spi_mosi <= 1'b0;
                            gapcnt   <= 1'b0;
                            done     <= 1'b1;
                        end else begin
                            shreg    <= {shreg[6:0], 1'b0};
                            spi_mosi <= shreg[6];
                        end
                    end
                end
                default: if (tick) begin
                    gapcnt <= 1'b1;
                    if (gapcnt) state <= S_IDLE;
                end
            endcase
        end
    end

    a_r12_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |=> spi_cs_n);
    a_r10_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);
    a_r10_mosi_stable: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sclk) |-> $stable(spi_mosi));
    a_r11_start_only_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/sar_spi_reader.sv
module sar_spi_reader
    import sar_rd_pkg::*;
#(
    parameter int CLK_DIV_HALF = 2,
    parameter int RES_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [2:0]       req_chan,
    input  logic             req_diff,
    input  logic [3:0]       req_variant,
    output logic             busy,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    variant_e   req_var;
    variant_e   cur_var;
    frame_cfg_t cfg;
    logic       start;
    logic       frame_done;
    logic [15:0] rx_word;

    assign req_var = norm_variant(req_variant);
    assign cfg     = build_cfg(req_var, req_chan, req_diff);
    assign start   = req_valid && !busy;

    sar_frame_ctrl #(.HALF(CLK_DIV_HALF)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cfg      (cfg),
        .spi_miso (spi_miso),
        .busy     (busy),
        .done     (frame_done),
        .rx_word  (rx_word),
        .spi_cs_n (spi_cs_n),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_var   <= V_1IN_10;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= frame_done;
            if (start)
                cur_var <= req_var;
            if (frame_done)
                res_data <= RES_W'(align_result(cur_var, rx_word));
        end
    end

    a_r12_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    a_r12_valid_cs_high: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> spi_cs_n);
    a_r3_no_mosi_single: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && cur_var <= V_1IN_13S) |-> !spi_mosi);
endmodule

// File: tb/sar_spi_reader_bench.sv
`timescale 1ns/1ps
module sar_spi_reader_bench;
    localparam int HALF  = 2;
    localparam int RES_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_chan = '0;
    logic req_diff = 1'b0;
    logic [3:0] req_variant = '0;
    logic busy, res_valid, spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b0;
    logic [RES_W-1:0] res_data;

    always #4 clk = ~clk;

    sar_spi_reader #(.CLK_DIV_HALF(HALF), .RES_W(RES_W)) u_sar_spi_reader (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .req_diff(req_diff), .req_variant(req_variant), .busy(busy),
        .res_valid(res_valid), .res_data(res_data), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] res;
        logic [7:0]  cmd;
        bit          has_cmd;
        string       rtag;
        string       ctag;
    } sb_item_t;
    sb_item_t sb_q[$];

    // converter model: shifts out on falling SCLK, captures MOSI on rising SCLK
    logic [15:0] next_pat = '0;
    logic [23:0] slv_out = '0;
    logic [23:0] mosi_cap = '0;
    int          edges = 0;

    always @(negedge spi_cs_n) begin
        slv_out  = {8'hC3, next_pat};
        if (!(req_variant >= 4'd3 && req_variant <= 4'd8)) slv_out = {next_pat, 8'h00};
        spi_miso = slv_out[23];
        edges    = 0;
        mosi_cap = '0;
    end
    always @(negedge spi_sclk) if (!spi_cs_n) begin
        slv_out  = {slv_out[22:0], 1'b0};
        spi_miso = slv_out[23];
    end
    always @(posedge spi_sclk) begin
        mosi_cap = {mosi_cap[22:0], spi_mosi};
        edges    = edges + 1;
    end

    function automatic logic [15:0] exp_res(input logic [3:0] v, input logic [15:0] p);
        case (v)
            4'd1:             return {4'b0, p[12:1]};
            4'd2:             return {{3{p[12]}}, p[12:0]};
            4'd3, 4'd5, 4'd7: return {6'b0, p[15:6]};
            4'd4, 4'd6, 4'd8: return {4'b0, p[15:4]};
            default:          return {6'b0, p[12:3]};
        endcase
    endfunction

    function automatic logic [7:0] exp_cmd(input logic [3:0] v, input logic [2:0] ch,
                                           input logic d);
        logic [7:0] c = 8'h00;
        if (v == 4'd3 || v == 4'd4) c = 8'h10 | (d ? 8'h00 : 8'h08) | (ch[0] ? 8'h04 : 8'h00);
        else if (v == 4'd5 || v == 4'd6) c = 8'h40 | (d ? 8'h00 : 8'h20) | {4'b0, ch[1:0], 2'b0};
        else if (v == 4'd7 || v == 4'd8) c = 8'h40 | (d ? 8'h00 : 8'h20) | {3'b0, ch, 2'b0};
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] v, input logic [2:0] ch, input logic d,
                         input logic [15:0] pat, input string rtag);
        sb_item_t it;
        while (busy) @(negedge clk);
        it.res     = exp_res(v, pat);
        it.cmd     = exp_cmd(v, ch, d);
        it.has_cmd = (v >= 4'd3 && v <= 4'd8);
        it.rtag    = rtag;
        it.ctag    = it.has_cmd ? ((v <= 4'd4) ? "R2" : "R1") : "R3";
        sb_q.push_back(it);
        next_pat    = pat;
        req_variant = v;
        req_chan    = ch;
        req_diff    = d;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) if (!rst && res_valid) begin
        sb_item_t it;
        if (sb_q.size() == 0) begin
            check(1'b0, "R11", "unexpected result", {16'b0, res_data}, 32'h0);
        end else begin
            it = sb_q.pop_front();
            check(res_data == it.res, it.rtag, "result", {16'b0, res_data}, {16'b0, it.res});
            if (it.has_cmd) begin
                check(edges == 24, "R4", "edge count", edges, 24);
                check(mosi_cap[23:16] == it.cmd, it.ctag, "command byte",
                      {24'b0, mosi_cap[23:16]}, {24'b0, it.cmd});
            end else begin
                check(edges == 16, "R3", "edge count", edges, 16);
                check(mosi_cap[15:0] == 16'h0, "R3", "mosi during frame",
                      {16'b0, mosi_cap[15:0]}, 32'h0);
            end
        end
    end

    // bus timing monitor
    logic p_sclk = 1'b0, p_mosi = 1'b0, p_cs = 1'b1, p_vld = 1'b0;
    int   since_rise = 0, cs_high = 1000;
    bit   first_rise = 1;
    always @(negedge clk) if (!rst) begin
        since_rise++;
        if (spi_cs_n) cs_high++;
        if (p_cs && !spi_cs_n) begin
            check(cs_high >= 2*HALF, "R12", "cs gap", cs_high, 2*HALF);
            first_rise = 1;
        end
        if (!spi_cs_n) cs_high = 0;
        if (spi_sclk && !p_sclk) begin
            if (!first_rise)
                check(since_rise == 2*HALF, "R10", "sclk period", since_rise, 2*HALF);
            first_rise = 0;
            since_rise = 0;
        end
        if (spi_sclk && p_sclk && spi_mosi != p_mosi)
            check(1'b0, "R10", "mosi moved while sclk high", spi_mosi, p_mosi);
        if (spi_cs_n && spi_sclk)
            check(1'b0, "R10", "sclk high while deselected", 1, 0);
        if (res_valid && p_vld)
            check(1'b0, "R12", "valid wider than one cycle", 1, 0);
        p_sclk = spi_sclk; p_mosi = spi_mosi; p_cs = spi_cs_n; p_vld = res_valid;
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(spi_cs_n == 1'b1, "R12", "reset cs_n", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R10", "reset sclk", spi_sclk, 0);
        check(busy == 1'b0, "R11", "reset busy", busy, 0);
        check(res_valid == 1'b0, "R12", "reset valid", res_valid, 0);
        rst = 1'b0;
        @(negedge clk);

        issue(4'd8, 3'd5, 1'b0, 16'hABCD, "R6");
        issue(4'd7, 3'd6, 1'b1, 16'h5A3F, "R5");
        issue(4'd6, 3'd7, 1'b0, 16'h1234, "R6");
        issue(4'd5, 3'd2, 1'b1, 16'hFFC0, "R5");
        issue(4'd3, 3'd1, 1'b0, 16'h8040, "R9");
        issue(4'd4, 3'd3, 1'b1, 16'h0FF0, "R6");
        issue(4'd0, 3'd4, 1'b0, 16'hFFFF, "R7");
        issue(4'd1, 3'd0, 1'b1, 16'h1ABE, "R7");
        issue(4'd2, 3'd0, 1'b1, 16'h1F00, "R8");
        issue(4'd2, 3'd0, 1'b1, 16'hE0FF, "R8");
        issue(4'd2, 3'd0, 1'b1, 16'h1000, "R8");
        issue(4'd12, 3'd7, 1'b0, 16'h0AA8, "R3");

        // R11: request raised mid-frame must be ignored
        issue(4'd7, 3'd0, 1'b0, 16'h3C3C, "R5");
        repeat (10) @(negedge clk);
        req_variant = 4'd8; req_chan = 3'd3; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        issue(4'd8, 3'd1, 1'b1, 16'hC3A5, "R6");

        while (busy) @(negedge clk);
        repeat (20) @(negedge clk);
        check(sb_q.size() == 0, "R11", "pending results", sb_q.size(), 0);
        finish_run();
    end
endmodule